// File: doc/BRIEF.md
# DC-Only Block Reconstruction

This block rebuilds a luma block whose residual carries nothing but a DC coefficient. When only the DC term is present, the full inverse transform reduces to one constant residual. The block computes that constant once and adds it to every prediction pixel, clipping each sum to the 8-bit pixel range. It has two block sizes: 4x4 (four rows of four pixels) and 8x8 (eight rows of eight pixels).

A start pulse latches the block size and the inputs that the residual depends on: the quantized DC coefficient, the inverse-scale entry, the weight entry, the qp/6 shift and, for 4x4 blocks, an optional DC value that was computed elsewhere. One cycle after the start pulse, the residual is ready. Prediction rows then enter one row at a time through a valid/ready handshake. The reconstructed rows leave in the same order through a second valid/ready handshake, and a one-cycle done pulse follows the last row.

Top module: `dc_recon`

## Requirements
- R1: After reset, `busy`, `in_ready`, `out_valid` and `done` are all low.
- R2: While `busy` is low, a `start` pulse latches the mode and all operands and raises `busy`. While `busy` is high, `start` and all operand inputs are ignored, and the block in progress finishes with the values latched at its start.
- R3: Dequantization takes the low 16 bits of `iscale * weight`, reads them as a signed two's-complement number, and multiplies that number by the signed `coef` to form a 32-bit product. The product is shifted left by `qp_shift`, and only the low 32 bits are kept.
- R4: When `blk8`=0 (4x4 mode), the DC value is (dequantized + 8) >>> 4, computed without overflow and then saturated to -32768..32767.
- R5: When `blk8`=1 (8x8 mode), the DC value is (dequantized + 32) >>> 6, computed without overflow and then saturated to -32768..32767.
- R6: In 4x4 mode with `use_ext_dc`=1, dequantization is bypassed and `ext_dc` becomes the DC value.
- R7: In 8x8 mode, `use_ext_dc` and `ext_dc` have no effect.
- R8: The residual is (DC + 32) >>> 6. It always lies in -512..512.
- R9: Each output pixel equals the prediction pixel (unsigned) plus the residual, clipped to 0..255.
- R10: Pixel k of a row is held in bits [8k+7:8k]. A 4x4 block has 4 rows that use pixels 0..3. In 4x4 mode, output pixels 4..7 are zero and input pixels 4..7 are ignored. An 8x8 block has 8 rows that use pixels 0..7.
- R11: `in_ready` stays low while the block is idle and during the cycle in which the residual is computed. Output rows appear in input order. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_row` hold.
- R12: In the cycle after the last output row is accepted, `done` is high for exactly one cycle and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a block (sampled only while idle) |
| blk8 | input | 1 | 1 = 8x8 block, 0 = 4x4 block |
| coef | input | 16 | Signed quantized DC coefficient |
| iscale | input | 16 | Inverse-scale entry |
| weight | input | 16 | Weight entry |
| qp_shift | input | QPW | qp/6 left-shift amount |
| use_ext_dc | input | 1 | Use `ext_dc` instead of dequantizing (4x4 only) |
| ext_dc | input | 16 | Signed precomputed DC value |
| busy | output | 1 | A block is in progress |
| in_valid | input | 1 | Prediction row valid |
| in_ready | output | 1 | Prediction row accepted this cycle when valid |
| in_row | input | 64 | Prediction row, 8 pixels |
| out_valid | output | 1 | Reconstructed row valid |
| out_ready | input | 1 | Consumer accepts the row |
| out_row | output | 64 | Reconstructed row, 8 pixels |
| done | output | 1 | One-cycle pulse after the last row |

## Verification
The bench sweeps both modes over every shift from 0 to 8. It uses coefficients of zero, ±1, moderate values and both 16-bit extremes, and scale/weight pairs whose truncated product is small positive, large positive or negative after truncation. Together these separate correct low-16 truncation, signed reading, 32-bit wrap after the shift, rounding and both saturation limits. Prediction rows of all zeros, all 255s and random values show clipping at each end and plain addition in between. Junk in the unused upper pixels and a mismatched external DC show what each mode must ignore. Output stalls and a start pulse in the middle of a block show that rows hold and that operands are not re-latched.

// File: rtl/dc_recon.sv
module dc_recon #(
  parameter int QPW  = 4,
  parameter int NPIX = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 blk8,
  input  logic signed [15:0]   coef,
  input  logic [15:0]          iscale,
  input  logic [15:0]          weight,
  input  logic [QPW-1:0]       qp_shift,
  input  logic                 use_ext_dc,
  input  logic signed [15:0]   ext_dc,
  output logic                 busy,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [NPIX*8-1:0]    in_row,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [NPIX*8-1:0]    out_row,
  output logic                 done
);
  localparam int CW = $clog2(NPIX + 1);

  typedef enum logic [1:0] {S_IDLE, S_CALC, S_RUN} st_t;
  st_t st;

  logic               m8, use_q;
  logic signed [15:0] coef_q, ext_q;
  logic [15:0]        isc_q, wt_q;
  logic [QPW-1:0]     qp_q;
  logic signed [10:0] res_q;
  logic [CW-1:0]      cnt_in, cnt_out, nrows;
  logic               ov, done_q;
  logic [NPIX*8-1:0]  orow, recon;

  // dequantization
  logic [31:0]        sw_full;
  logic signed [31:0] sw_x, coef_x, prod, shifted;
  logic signed [32:0] rnd_add, rnd_q;
  logic signed [15:0] deq_sat, dc;
  logic signed [16:0] dr;
  logic signed [10:0] res_w;

  assign sw_full = 32'(isc_q) * 32'(wt_q);
  assign sw_x    = 32'($signed(sw_full[15:0]));
  assign coef_x  = 32'(coef_q);
  assign prod    = sw_x * coef_x;
  assign shifted = prod <<< qp_q;
  assign rnd_add = {shifted[31], shifted} + (m8 ? 33'sd32 : 33'sd8);
  assign rnd_q   = m8 ? (rnd_add >>> 6) : (rnd_add >>> 4);
  assign deq_sat = (rnd_q > 33'sd32767)  ? 16'sh7fff :
                   (rnd_q < -33'sd32768) ? 16'sh8000 : rnd_q[15:0];
  assign dc      = (!m8 && use_q) ? ext_q : deq_sat;
  assign dr      = {dc[15], dc} + 17'sd32;
  assign res_w   = dr[16:6];

  // per-pixel add and clip
  for (genvar k = 0; k < NPIX; k++) begin : g_pix
    logic signed [11:0] sum;
    logic [7:0]         clp;
    assign sum = $signed({4'b0, in_row[8*k +: 8]}) + 12'(res_q);
    assign clp = sum[11] ? 8'd0 : (sum > 12'sd255) ? 8'd255 : sum[7:0];
    if (k < 4) begin : g_lo
      assign recon[8*k +: 8] = clp;
    end else begin : g_hi
      assign recon[8*k +: 8] = m8 ? clp : 8'd0;
    end
  end

  assign nrows     = m8 ? CW'(NPIX) : CW'(4);
  assign busy      = (st != S_IDLE);
  assign in_ready  = (st == S_RUN) && (cnt_in != nrows) && (!ov || out_ready);
  assign out_valid = ov;
  assign out_row   = orow;
  assign done      = done_q;

  wire in_fire  = in_valid && in_ready;
  wire out_fire = ov && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; m8 <= 1'b0; use_q <= 1'b0;
      coef_q <= '0; ext_q <= '0; isc_q <= '0; wt_q <= '0; qp_q <= '0;
      res_q <= '0; cnt_in <= '0; cnt_out <= '0;
      ov <= 1'b0; orow <= '0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          m8 <= blk8; use_q <= use_ext_dc; coef_q <= coef; ext_q <= ext_dc;
          isc_q <= iscale; wt_q <= weight; qp_q <= qp_shift;
          cnt_in <= '0; cnt_out <= '0;
          st <= S_CALC;
        end
        S_CALC: begin
          res_q <= res_w;
          st <= S_RUN;
        end
        S_RUN: begin
          if (in_fire) cnt_in <= cnt_in + 1'b1;
          if (out_fire) begin
            cnt_out <= cnt_out + 1'b1;
            if (cnt_out == nrows - 1'b1) begin
              done_q <= 1'b1;
              st <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
      if (in_fire) begin
        orow <= recon;
        ov <= 1'b1;
      end else if (out_fire) begin
        ov <= 1'b0;
      end
    end
  end

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ov && !out_ready |=> ov && $stable(orow));
  // R11
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !in_ready);
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !ov);
  // R2
  operand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN) && start |=> $stable(coef_q) && $stable(m8) && $stable(qp_q));
  // R8
  res_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN) |-> (res_q >= -11'sd512) && (res_q <= 11'sd512));
  // R10
  row_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_out <= cnt_in) && (cnt_in <= nrows));
endmodule

// File: tb/test_dc_recon.sv
module test_dc_recon;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, blk8 = 0, use_ext_dc = 0, in_valid = 0, out_ready = 0;
  logic signed [15:0] coef = 0, ext_dc = 0;
  logic [15:0] iscale = 0, weight = 0;
  logic [3:0] qp_shift = 0;
  logic [63:0] in_row = 0;
  logic busy, in_ready, out_valid, done;
  logic [63:0] out_row;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  dc_recon i_dc_recon (
    .clk(clk), .rst_n(rst_n), .start(start), .blk8(blk8), .coef(coef),
    .iscale(iscale), .weight(weight), .qp_shift(qp_shift),
    .use_ext_dc(use_ext_dc), .ext_dc(ext_dc), .busy(busy),
    .in_valid(in_valid), .in_ready(in_ready), .in_row(in_row),
    .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row), .done(done));

  task automatic chk(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int ref_dc(bit m8, int c, int isc, int wt, int qp, bit ue, int ext);
    longint p; int lo; int n;
    if (!m8 && ue) return ext;
    lo = (isc * wt) & 32'hFFFF;
    if (lo >= 32768) lo -= 65536;
    p = longint'(lo) * longint'(c);
    p = p * (longint'(1) << qp);
    p = p & 64'hFFFF_FFFF;
    if (p >= 64'sh8000_0000) p -= 64'sh1_0000_0000;
    n = m8 ? 6 : 4;
    p = (p + (longint'(1) << (n - 1))) >>> n;
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return int'(p);
  endfunction

  function automatic logic [63:0] ref_row(bit m8, int res, logic [63:0] pr);
    logic [63:0] r = '0;
    for (int k = 0; k < 8; k++) begin
      int s = int'(pr[8*k +: 8]) + res;
      if (s < 0) s = 0;
      if (s > 255) s = 255;
      if (m8 || k < 4) r[8*k +: 8] = 8'(s);
    end
    return r;
  endfunction

  task automatic run_block(input bit m8, input int c, input int isc, input int wt,
                           input int qp, input bit ue, input int ext,
                           input int pat, input bit poke, input string req);
    int res, nr;
    logic [63:0] pr, er;
    res = (ref_dc(m8, c, isc, wt, qp, ue, ext) + 32) >>> 6;
    nr = m8 ? 8 : 4;
    @(negedge clk);
    blk8 = m8; coef = 16'(c); iscale = 16'(isc); weight = 16'(wt);
    qp_shift = 4'(qp); use_ext_dc = ue; ext_dc = 16'(ext); start = 1;
    @(negedge clk);
    start = 0;
    chk("R11 ready low during residual cycle", in_ready, 0);
    chk("R2 busy after start", busy, 1);
    for (int r = 0; r < nr; r++) begin
      for (int k = 0; k < 8; k++)
        pr[8*k +: 8] = (pat == 0) ? 8'd0 : (pat == 1) ? 8'd255 : 8'($urandom);
      in_row = pr; in_valid = 1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 0; in_row = {8{8'hA5}};
      er = ref_row(m8, res, pr);
      chk("R11 out_valid after row", out_valid, 1);
      chk({req, " R9 R10 row value"}, out_row, er);
      if (r % 2 == 1) begin
        if (poke) begin
          blk8 = ~m8; coef = 16'sh7fff; iscale = 16'd1; weight = 16'd1;
          qp_shift = 4'd8; use_ext_dc = 1; ext_dc = 16'sh7fff; start = 1;
        end
        @(negedge clk);
        start = 0;
        @(negedge clk);
        chk("R11 stalled row held", out_row, er);
        chk("R11 stalled valid held", out_valid, 1);
      end
      out_ready = 1;
      @(negedge clk);
      out_ready = 0;
    end
    chk("R12 done after last row", done, 1);
    chk("R12 idle after last row", busy, 0);
    @(negedge clk);
    chk("R12 done single cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy at reset", busy, 0);
    chk("R1 in_ready at reset", in_ready, 0);
    chk("R1 out_valid at reset", out_valid, 0);
    chk("R1 done at reset", done, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R11 in_ready idle", in_ready, 0);
    begin
      int coefs[7] = '{0, 1, -1, 37, -300, 32767, -32768};
      int scl[3]   = '{16, 300, 200};
      int wts[3]   = '{1, 250, 200};
      int it = 0;
      for (int m = 0; m < 2; m++)
        for (int q = 0; q <= 8; q++)
          for (int ci = 0; ci < 7; ci++)
            for (int si = 0; si < 3; si++) begin
              run_block(m[0], coefs[ci], scl[si], wts[si], q, 0, 0, it % 3, 0,
                        m ? "R3 R5 R8" : "R3 R4 R8");
              it++;
            end
      // R6: external DC bypass in 4x4 mode
      for (int e = -32768; e <= 32767; e += 4099)
        run_block(0, 1234, 300, 250, 3, 1, e, 2, 0, "R6");
      run_block(0, 0, 0, 0, 0, 1, 32767, 0, 0, "R6");
      run_block(0, 0, 0, 0, 0, 1, -32768, 1, 0, "R6");
      // R7: external DC ignored in 8x8 mode
      run_block(1, 500, 16, 1, 2, 1, 32767, 2, 0, "R7");
      run_block(1, -500, 16, 1, 2, 1, -32768, 2, 0, "R7");
      // R2: start in mid-block ignored
      run_block(0, 100, 16, 1, 1, 0, 0, 2, 1, "R2");
      run_block(1, -100, 16, 1, 1, 0, 0, 2, 1, "R2");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule